// File: doc/BRIEF.md
# Cascaded Level Interrupt Controller

This block gathers up to 32 level-sensitive, active-high interrupt sources into one request line for a parent interrupt controller. Each source passes through a two-flop synchroniser. It is then gated by its own enable bit. The request line is asserted while any enabled source is pending. A pending bit follows its input level and is never latched, so a source stays pending until the device behind it drops its request.

Software reaches the block through a simple 32-bit register port with a word address, a write strobe, write data and combinational read data. Two read-only views are provided: the gated (masked) status and the raw synchronised inputs. Enables change only through two write-one registers, one that sets bits and one that clears them. A single source can therefore be enabled or disabled without a read-modify-write. A helper output gives the index of the lowest-numbered pending source, which is the one software services first, together with a valid flag.

Top module: `lvl_irq_agg`

## Requirements
- R1: After reset all enable bits are 0, `irq_out` and `pend_vld` are 0, and reading word 2 returns 0.
- R2: Reading word 1 (byte 0x4) returns the inputs as they stood two rising clock edges earlier, whatever the enable bits are.
- R3: Reading word 0 (byte 0x0) returns the raw status ANDed bitwise with the enable vector.
- R4: A write to word 2 (byte 0x8) sets each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R5: A write to word 3 (byte 0xC) clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R6: Reads of word 2 and word 3 both return the enable vector. Writes to word 0 and word 1 leave the enables unchanged.
- R7: Pending bits are not latched. When a source deasserts, its raw and masked bits read 0 two edges later.
- R8: `irq_out` is registered. It is 1 in the cycle after any masked-status bit was 1, and 0 otherwise.
- R9: `pend_vld` is 1 when any masked bit is set. `pend_idx` then carries the index of the least significant set masked bit, and reads 0 when `pend_vld` is 0.
- R10: A disable write to an asserted, enabled source removes that source from the masked status immediately after the write edge. This also holds when a set write and a clear write are issued back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Level interrupt sources, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (combinational) |
| irq_out | output | 1 | Registered combined request to the parent controller |
| pend_idx | output | 5 | Index of the lowest pending enabled source |
| pend_vld | output | 1 | Some enabled source is pending |

## Verification
An enable write and a change of input level can reach the status logic in the same cycle. A disable write can also remove the source that `pend_idx` currently points at. The bench provokes both cases: it issues set and clear writes back to back on adjacent edges, it disables a source that is asserted and lowest-pending, and it interleaves random enable writes with random input changes. Each result is judged against a bench model of the enables and of the synchronised inputs, covering masked status, raw status, the request line and the lowest-index output.

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg #(
  parameter int NSRC = 32,
  parameter int AW   = 2,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdata,
  output logic            irq_out,
  output logic [IW-1:0]   pend_idx,
  output logic            pend_vld
);

  localparam logic [AW-1:0] A_MSK = AW'(0);
  localparam logic [AW-1:0] A_RAW = AW'(1);
  localparam logic [AW-1:0] A_SET = AW'(2);
  localparam logic [AW-1:0] A_CLR = AW'(3);

  logic [NSRC-1:0] sync1, raw, en, masked;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      raw   <= '0;
    end else begin
      sync1 <= irq_in;
      raw   <= sync1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      en <= '0;
    else if (wr_en && addr == A_SET)
      en <= en | wdata;
    else if (wr_en && addr == A_CLR)
      en <= en & ~wdata;

  assign masked   = raw & en;
  assign pend_vld = |masked;

  always_comb begin
    pend_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (masked[i]) pend_idx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= |masked;

  always_comb
    case (addr)
      A_MSK:   rdata = masked;
      A_RAW:   rdata = raw;
      default: rdata = en;
    endcase

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET) |=> ((en & $past(wdata)) == $past(wdata)));

  // R5
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR) |=> ((en & $past(wdata)) == '0));

  // R6
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || addr == A_MSK || addr == A_RAW) |=> (en == $past(en)));

  // R8
  out_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(pend_vld));

  // R9
  low_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld |-> (masked[pend_idx] &&
                  ((masked & ((NSRC'(1) << pend_idx) - NSRC'(1))) == '0)));

  // R2
  raw_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |=> (raw == $past(sync1)));

endmodule

// File: tb/lvl_irq_agg_bench.sv
module lvl_irq_agg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out;
  logic [4:0]  pend_idx;
  logic        pend_vld;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_en = '0;
  logic [31:0] m_in = '0;

  always #2 clk = ~clk;

  lvl_irq_agg u_lvl_irq_agg (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .pend_idx(pend_idx),
    .pend_vld(pend_vld));

  function automatic logic [4:0] lowest(input logic [31:0] m);
    for (int i = 0; i < 32; i++) if (m[i]) return 5'(i);
    return 5'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 2'd2) m_en = m_en | d;
    else if (a == 2'd3) m_en = m_en & ~d;
  endtask

  task automatic drive_in(input logic [31:0] v);
    @(negedge clk);
    irq_in = v;
    m_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic full_check(input string tag);
    logic [31:0] d;
    rd(2'd0, d); chk({"R3 ", tag}, d, m_in & m_en);
    rd(2'd1, d); chk({"R2 ", tag}, d, m_in);
    rd(2'd2, d); chk({"R6 ", tag}, d, m_en);
    chk({"R9 vld ", tag}, 32'(pend_vld), 32'(|(m_in & m_en)));
    chk({"R9 idx ", tag}, 32'(pend_idx), 32'(lowest(m_in & m_en)));
    @(negedge clk);
    chk({"R8 ", tag}, 32'(irq_out), 32'(|(m_in & m_en)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd2, d); chk("R1 en", d, 32'h0);
    chk("R1 irq_out", 32'(irq_out), 32'h0);
    chk("R1 pend_vld", 32'(pend_vld), 32'h0);

    // R2: raw independent of enables
    drive_in(32'hA5A5_0F0F);
    full_check("raw with en=0");
    wr(2'd2, 32'hFFFF_FFFF);
    full_check("all enabled");
    wr(2'd3, 32'hFFFF_FFFF);
    full_check("all disabled");

    // R6: writes to status words ignored
    wr(2'd2, 32'h0000_00F0);
    @(negedge clk); wr_en = 1'b1; addr = 2'd0; wdata = 32'hFFFF_FFFF;
    @(negedge clk); addr = 2'd1; wdata = 32'h0;
    @(negedge clk); wr_en = 1'b0;
    rd(2'd3, d); chk("R6 word3 read/ignored writes", d, 32'h0000_00F0);

    // R10: back-to-back set then clear
    @(negedge clk); wr_en = 1'b1; addr = 2'd2; wdata = 32'hFF00_FF00;
    @(negedge clk); addr = 2'd3; wdata = 32'h0F0F_0F0F;
    @(negedge clk); wr_en = 1'b0;
    m_en = (m_en | 32'hFF00_FF00) & ~32'h0F0F_0F0F;
    rd(2'd2, d); chk("R10 back-to-back", d, 32'hF000_F0F0);
    full_check("after back-to-back");

    // R10: mask asserted lowest source, removed right after the edge
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd2, 32'h0000_0120);
    drive_in(32'h0000_0120);
    chk("R9 idx before mask", 32'(pend_idx), 32'd5);
    @(negedge clk); wr_en = 1'b1; addr = 2'd3; wdata = 32'h0000_0020;
    @(negedge clk); wr_en = 1'b0; m_en = m_en & ~32'h20;
    rd(2'd0, d); chk("R10 masked next cycle", d, 32'h0000_0100);
    chk("R10 idx moves", 32'(pend_idx), 32'd8);
    full_check("after mask");

    // R7: level not latched
    drive_in(32'h0);
    full_check("R7 deassert");
    rd(2'd0, d); chk("R7 masked clear", d, 32'h0);

    for (int k = 0; k < 300; k++) begin
      int op = $urandom_range(0, 2);
      logic [31:0] v = $urandom;
      if ($urandom_range(0, 3) == 0) v = v & (v - 1) & 32'h8000_0001;
      case (op)
        0: wr(2'd2, v & $urandom);
        1: wr(2'd3, v);
        default: drive_in(v);
      endcase
      repeat (3) @(negedge clk);
      full_check("random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule